// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a 32-bit wide synchronous SRAM with a pipelined read path and a two-bit burst address counter. A host samples its controls on every rising clock edge: a chip select, an address load strobe, a write select and one write mask bit per byte lane. An output enable gates the drive of the read data path at once, without waiting for a clock edge. The storage is a small array whose depth is set by a parameter.

The address strobe starts every burst. While the strobe stays high, the burst goes on. With the chip select low, the two low address bits step forward and wrap within a group of four words. With the chip select high, the current address is held and accessed again, which inserts a wait. The read data path has one register stage. A read's word appears after the second rising edge that follows the command. The data path has a separate drive-enable output that stands for the tri-state control.

Top module: `pipe_burst_sram`

## Requirements
- R1: When strobe_n is low and ce_n is high, the cycle is a deselect. It ends any burst, and no data is driven after the second following edge. Later cycles with strobe_n high start no access until a new load.
- R2: When strobe_n is low, ce_n is low and we_n is high, a read burst starts at addr. The word at that address is placed on dq_o with dq_oe high, provided oe_n is low.
- R3: During a burst, a cycle with strobe_n high and ce_n high is a suspend. It accesses the same address as the previous access and leaves the burst address unchanged.
- R4: During a burst, a cycle with strobe_n high and ce_n low advances the burst. Address bits [1:0] step up by one modulo 4 (3 wraps to 0) and the upper address bits stay unchanged.
- R5: In a write, byte lane i (bits 8i+7 down to 8i) is stored only when we_n is low and be_n[i] is low. Lanes whose be_n bit is high keep their old contents. When we_n is high, be_n has no effect.
- R6: dq_oe is high only while oe_n is low, and it follows oe_n within the same clock cycle.
- R7: dq_oe is low while rst_n is low, including right after reset is asserted during a read. It stays low after reset until a read result is available.
- R8: A read command sampled at edge k drives its data only after edge k+1. After edge k alone, dq_oe still reflects the previous command.
- R9: When strobe_n is low, ce_n is low and we_n is low, a write burst starts and stores wdata at addr. Continue cycles with we_n low store at the following burst addresses. A write never raises dq_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| strobe_n | input | 1 | Address load strobe, active low |
| we_n | input | 1 | Write select, active low |
| be_n | input | DATA_W/8 | Per-lane write mask, active low; bit i covers bits 8i+7:8i |
| oe_n | input | 1 | Output enable, active low, acts without a clock edge |
| addr | input | ADDR_W | Word address; bits [1:0] are the burst bits |
| wdata | input | DATA_W | Write data, sampled with the command |
| dq_o | output | DATA_W | Read data |
| dq_oe | output | 1 | Drive enable of the data path (low means high impedance) |

## Verification
The bench writes a burst of five words so that the counter wraps from 3 back to the first word. A counter that carried into the upper address bits would then read back an unwritten location. It mixes advance, suspend and deselect cycles, so a design that advanced during a suspend, or that kept a burst alive after a deselect, would return the wrong word or drive the bus when it should not. Byte writes with sparse masks, and with an all-high mask, expose lanes that are written when they should not be. It also checks the read latency edge by edge, toggles the output enable in the middle of a cycle, and asserts reset during a read. These catch a data path that is one stage short, an output enable that waits for the clock, and a drive register that survives reset.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_LOAD,
    CMD_DESEL,
    CMD_NEXT,
    CMD_HOLD
  } cmd_e;
endpackage

// File: rtl/psram_decode.sv
module psram_decode
  import psram_pkg::*;
(
  input  logic strobe_n,
  input  logic ce_n,
  input  logic burst_on,
  output cmd_e cmd
);
  always_comb begin
    if (!strobe_n) begin
      cmd = ce_n ? CMD_DESEL : CMD_LOAD;
    end else if (!burst_on) begin
      cmd = CMD_IDLE;
    end else begin
      cmd = ce_n ? CMD_HOLD : CMD_NEXT;
    end
  end
endmodule

// File: rtl/psram_burst.sv
module psram_burst
  import psram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              access,
  output logic              burst_on
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  cur_addr;
  logic [ADDR_W-1:0]  cur_addr_nxt;
  logic               burst_on_nxt;
  logic [BURST_W-1:0] step;

  assign step = cur_addr[BURST_W-1:0] + {{(BURST_W-1){1'b0}}, 1'b1};

  always_comb begin
    access = 1'b0;
    acc_addr = cur_addr;
    case (cmd)
      CMD_LOAD: begin access = 1'b1; acc_addr = ext_addr; end
      CMD_NEXT: begin access = 1'b1; acc_addr = {cur_addr[ADDR_W-1:BURST_W], step}; end
      CMD_HOLD: begin access = 1'b1; acc_addr = cur_addr; end
      default:  begin access = 1'b0; acc_addr = cur_addr; end
    endcase
    cur_addr_nxt = access ? acc_addr : cur_addr;
    if (cmd == CMD_LOAD) begin
      burst_on_nxt = 1'b1;
    end else if (cmd == CMD_DESEL) begin
      burst_on_nxt = 1'b0;
    end else begin
      burst_on_nxt = burst_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      burst_on <= 1'b0;
    end else begin
      if (access) begin
        cur_addr <= cur_addr_nxt;
      end
      burst_on <= burst_on_nxt;
    end
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [LANES-1:0]   be_n,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LANES*8-1:0] wdata,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [LANES*8-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic       lane_we;

    assign lane_we = wr_en & ~be_n[g];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        mem[wr_addr] <= wdata[g*8 +: 8];
      end
    end

    assign rdata[g*8 +: 8] = mem[rd_addr];
  end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import psram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  strobe_n,
  input  logic                  we_n,
  input  logic [DATA_W/8-1:0]   be_n,
  input  logic                  oe_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     dq_o,
  output logic                  dq_oe
);
  localparam int LANES = DATA_W / 8;

  cmd_e              cmd;
  logic              burst_on;
  logic              access;
  logic [ADDR_W-1:0] acc_addr;
  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] arr_rdata;

  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_pend_q;
  logic              rd_pend_nxt;
  logic [DATA_W-1:0] dq_q;
  logic              drv_q;

  psram_decode u_decode (
    .strobe_n (strobe_n),
    .ce_n     (ce_n),
    .burst_on (burst_on),
    .cmd      (cmd)
  );

  psram_burst #(.ADDR_W(ADDR_W), .BURST_W(2)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .ext_addr (addr),
    .acc_addr (acc_addr),
    .access   (access),
    .burst_on (burst_on)
  );

  assign wr_en = access & ~we_n;
  assign rd_en = access & we_n;

  psram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .be_n    (be_n),
    .wr_addr (acc_addr),
    .wdata   (wdata),
    .rd_addr (rd_addr_q),
    .rdata   (arr_rdata)
  );

  assign rd_pend_nxt = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_pend_q <= 1'b0;
      dq_q      <= '0;
      drv_q     <= 1'b0;
    end else begin
      if (rd_en) begin
        rd_addr_q <= acc_addr;
      end
      if (rd_pend_q) begin
        dq_q <= arr_rdata;
      end
      rd_pend_q <= rd_pend_nxt;
      drv_q     <= rd_pend_q;
    end
  end

  assign dq_o  = dq_q;
  assign dq_oe = drv_q & ~oe_n;
endmodule

// File: rtl/pipe_burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic strobe_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_hiz_r7: assert (!dq_oe);
    end
  end

  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!strobe_n && ce_n, 2) |-> !dq_oe);

  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!strobe_n && !ce_n && we_n, 2) && !oe_n) |-> dq_oe);

  p_write_nodrive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!strobe_n && !ce_n && !we_n, 2) |-> !dq_oe);
endmodule

module burst_addr_chk
  import psram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input cmd_e              cmd,
  input logic [ADDR_W-1:0] cur_addr
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=> $stable(cur_addr));

  p_next_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NEXT) |=>
      (cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + {{(BURST_W-1){1'b0}}, 1'b1}));

  p_next_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NEXT) |=> $stable(cur_addr[ADDR_W-1:BURST_W]));
endmodule

bind pipe_burst_sram burst_sram_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .strobe_n (strobe_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .dq_oe    (dq_oe)
);

bind psram_burst burst_addr_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      (cmd),
  .cur_addr (cur_addr)
);

// File: tb/tb_pipe_burst_sram.sv
module tb_pipe_burst_sram;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int NROWS  = 19;

  typedef struct packed {
    logic [3:0]  req;
    logic        strobe_n;
    logic        ce_n;
    logic        we_n;
    logic [3:0]  be_n;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        exp_oe;
    logic [31:0] exp_data;
  } row_t;

  // Each row's expectation is the result of the row before it.
  localparam row_t TBL [NROWS] = '{
    '{4'd9, 1'b0, 1'b0, 1'b0, 4'b0000, 6'h08, 32'h11111111, 1'b0, 32'h0},        // R9 write load
    '{4'd9, 1'b1, 1'b0, 1'b0, 4'b0000, 6'h00, 32'h22222222, 1'b0, 32'h0},        // R9 advance 09
    '{4'd9, 1'b1, 1'b0, 1'b0, 4'b0000, 6'h00, 32'h33333333, 1'b0, 32'h0},        // R9 advance 0A
    '{4'd9, 1'b1, 1'b0, 1'b0, 4'b0000, 6'h00, 32'h44444444, 1'b0, 32'h0},        // R9 advance 0B
    '{4'd4, 1'b1, 1'b0, 1'b0, 4'b0000, 6'h00, 32'h55555555, 1'b0, 32'h0},        // R4 wrap to 08
    '{4'd2, 1'b0, 1'b0, 1'b1, 4'b0000, 6'h09, 32'h0,        1'b0, 32'h0},        // R2 read load 09
    '{4'd2, 1'b1, 1'b0, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b1, 32'h22222222}, // R2 advance 0A
    '{4'd3, 1'b1, 1'b1, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b1, 32'h33333333}, // R3 suspend 0A
    '{4'd3, 1'b1, 1'b0, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b1, 32'h33333333}, // R3 advance 0B
    '{4'd4, 1'b1, 1'b0, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b1, 32'h44444444}, // R4 wrap 08
    '{4'd4, 1'b0, 1'b1, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b1, 32'h55555555}, // R4 deselect
    '{4'd1, 1'b1, 1'b1, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b0, 32'h0},        // R1 no burst
    '{4'd1, 1'b1, 1'b0, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b0, 32'h0},        // R1 no burst
    '{4'd1, 1'b0, 1'b0, 1'b0, 4'b1010, 6'h0A, 32'hAABBCCDD, 1'b0, 32'h0},        // R1 then R5 lanes 0,2
    '{4'd5, 1'b0, 1'b0, 1'b0, 4'b1111, 6'h0B, 32'hFFFFFFFF, 1'b0, 32'h0},        // R5 all masked
    '{4'd5, 1'b0, 1'b0, 1'b1, 4'b0000, 6'h0A, 32'h0,        1'b0, 32'h0},        // R5 read 0A
    '{4'd5, 1'b0, 1'b0, 1'b1, 4'b0000, 6'h0B, 32'h0,        1'b1, 32'h33BB33DD}, // R5 read 0B
    '{4'd5, 1'b0, 1'b1, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b1, 32'h44444444}, // R5 deselect
    '{4'd1, 1'b0, 1'b1, 1'b1, 4'b0000, 6'h00, 32'h0,        1'b0, 32'h0}         // R1 quiet
  };

  logic              clk;
  logic              rst_n;
  logic              ce_n;
  logic              strobe_n;
  logic              we_n;
  logic [3:0]        be_n;
  logic              oe_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] dq_o;
  logic              dq_oe;

  int checks;
  int fails;

  pipe_burst_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .strobe_n (strobe_n),
    .we_n     (we_n),
    .be_n     (be_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .wdata    (wdata),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic exp_oe, input logic [31:0] exp_data);
    checks++;
    if (dq_oe !== exp_oe || (exp_oe && dq_o !== exp_data)) begin
      fails++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
               tag, dq_oe, dq_o, exp_oe, exp_data);
    end
  endtask

  task automatic drive(input logic s, input logic c, input logic w,
                       input logic [3:0] b, input logic [5:0] a, input logic [31:0] d);
    strobe_n = s; ce_n = c; we_n = w; be_n = b; addr = a; wdata = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 1'b1, 4'hF, 6'h00, 32'h0);
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog: oe=%0b data=%h expected oe=0 data=0", dq_oe, dq_o);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    oe_n   = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #2;
    chk("R7 during reset", 1'b0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R7 after release", 1'b0, 32'h0);

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      drive(TBL[i].strobe_n, TBL[i].ce_n, TBL[i].we_n, TBL[i].be_n, TBL[i].addr, TBL[i].wdata);
      @(posedge clk);
      #2;
      chk($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp_oe, TBL[i].exp_data);
    end

    // R8: one edge is not enough for read data
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 4'h0, 6'h09, 32'h0);
    @(posedge clk);
    #2;
    chk("R8 first edge", 1'b0, 32'h0);
    @(negedge clk);
    idle();
    @(posedge clk);
    #2;
    chk("R8 second edge", 1'b1, 32'h22222222);

    // R6: output enable acts within the cycle
    oe_n = 1'b1;
    #1;
    chk("R6 oe high", 1'b0, 32'h0);
    oe_n = 1'b0;
    #1;
    chk("R6 oe low again", 1'b1, 32'h22222222);

    // R7: reset in the middle of a read
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 4'h0, 6'h08, 32'h0);
    @(negedge clk);
    idle();
    @(posedge clk);
    #2;
    chk("R7 read before reset", 1'b1, 32'h55555555);
    rst_n = 1'b0;
    #1;
    chk("R7 async reset", 1'b0, 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R7 after second reset", 1'b0, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule